// File: doc/BRIEF.md
# Output Compare Channel

This block is one channel of a general-purpose timer, used in output mode. It takes the timebase's running count and counting direction, compares the count with a compare value, and from that builds a reference waveform. A 3-bit mode input picks the waveform. The choices are:

- hold the current level
- drive high on a match
- drive low on a match
- toggle on a match
- force low
- force high
- two pulse-width modes that are mirror images of each other

A pin stage turns the reference into a main output and a complementary output. Each of these outputs has its own polarity and enable. When an output is disabled, it drives a chosen idle level.

The compare value is written through a strobe and can be double-buffered. With buffering on, a written value waits in a holding register until the timebase signals an update event. A sticky match flag records that the count has reached the active compare value. Software clears the flag through a strobe.

Top module: `oc_chan`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `ref_o`, `out_main_o`, `out_comp_o` and `match_flag_o` are all 0, and the active compare value is 0.
- R2: With `mode_i` = 3'b000, `ref_o` keeps its level whatever the count.
- R3: With `mode_i` = 3'b001, `ref_o` goes to 1 in the cycle after `count_i` equals the active compare value. With 3'b010 it goes to 0 instead. With no match, it keeps its level.
- R4: With `mode_i` = 3'b011, `ref_o` inverts in the cycle after each cycle in which `count_i` equals the active compare value.
- R5: With `mode_i` = 3'b100, `ref_o` is 0 one cycle later. With 3'b101 it is 1 one cycle later, whatever the count.
- R6: With `mode_i` = 3'b110, `ref_o` is 1 one cycle after a cycle with `count_i` < compare value while `count_down_i` = 0 (counting up). While `count_down_i` = 1 (counting down) it is 1 after a cycle with `count_i` <= compare value. Otherwise it is 0.
- R7: With `mode_i` = 3'b111, `ref_o` is the inverse of the R6 result in both directions.
- R8: The active compare value starts at 0. When `cmp_wr_i` is high, `cmp_wdata_i` is stored. With `preload_en_i` = 0 the stored value becomes active on the next clock. With `preload_en_i` = 1 it becomes active only at a clock where `update_i` is high; a value written in that same cycle is the one taken.
- R9: `match_flag_o` is 1 from the cycle after any cycle in which the count equals the active compare value, in every mode. It stays 1 until a cycle with `flag_clr_i` high and no match. A match wins over a clear in the same cycle.
- R10: `out_main_o` equals the previous cycle's `ref_o` XOR `main_pol_i` when `main_en_i` was 1. When `main_en_i` was 0, it equals the previous cycle's `main_idle_i`. Polarity 1 inverts.
- R11: `out_comp_o` equals the inverse of the previous cycle's `ref_o`, XOR `comp_pol_i`, when `comp_en_i` was 1. When `comp_en_i` was 0, it equals the previous cycle's `comp_idle_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_i | input | CNT_W | Timebase count |
| count_down_i | input | 1 | 1 = timebase counting down |
| update_i | input | 1 | Update event strobe from the timebase |
| mode_i | input | 3 | Compare behaviour select |
| preload_en_i | input | 1 | 1 = compare value double-buffered |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value to write |
| flag_clr_i | input | 1 | Clear strobe for the match flag |
| main_en_i | input | 1 | Main output enable |
| main_pol_i | input | 1 | Main output polarity (1 = inverted) |
| main_idle_i | input | 1 | Main output level when disabled |
| comp_en_i | input | 1 | Complementary output enable |
| comp_pol_i | input | 1 | Complementary output polarity (1 = inverted) |
| comp_idle_i | input | 1 | Complementary output level when disabled |
| ref_o | output | 1 | Reference waveform |
| out_main_o | output | 1 | Main pin-level output |
| out_comp_o | output | 1 | Complementary pin-level output |
| match_flag_o | output | 1 | Sticky compare-match flag |

## Verification
A wrong active compare value appears at the ports within one or two count periods. It moves the PWM edge, and it sets the match flag in a cycle where the count differs from the value that was written. A corrupted reference level shows on `ref_o` one clock after the fault. It then shows on both pin outputs one clock later, unless an output is disabled; a disabled output masks it. Buffering errors only show when a write lands between update events, so the bench writes compare values at random points in the count period with buffering both on and off.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_HOLD    = 3'b000,
    OC_SET     = 3'b001,
    OC_CLEAR   = 3'b010,
    OC_TOGGLE  = 3'b011,
    OC_LOW     = 3'b100,
    OC_HIGH    = 3'b101,
    OC_PWM_A   = 3'b110,
    OC_PWM_B   = 3'b111
  } oc_mode_e;

  localparam int OC_PINS = 2;
endpackage

// File: rtl/oc_cmp_hold.sv
module oc_cmp_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pre_en_i,
  input  logic         update_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] shadow_nxt;
  logic [W-1:0] act_q;

  assign shadow_nxt = wr_i ? wdata_i : shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      if (!pre_en_i && wr_i)
        act_q <= wdata_i;
      else if (pre_en_i && update_i)
        act_q <= shadow_nxt;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  oc_mode_e     mode_i,
  input  logic [W-1:0] count_i,
  input  logic         down_i,
  input  logic [W-1:0] cmp_i,
  output logic         hit_o,
  output logic         ref_o
);
  logic ref_q;
  logic ref_nxt;
  logic pwm_lvl;

  assign hit_o   = (count_i == cmp_i);
  // counting down the level is high up to and including the compare value
  assign pwm_lvl = down_i ? (count_i <= cmp_i) : (count_i < cmp_i);

  always_comb begin
    ref_nxt = ref_q;
    unique case (mode_i)
      OC_HOLD:   ref_nxt = ref_q;
      OC_SET:    ref_nxt = hit_o ? 1'b1 : ref_q;
      OC_CLEAR:  ref_nxt = hit_o ? 1'b0 : ref_q;
      OC_TOGGLE: ref_nxt = hit_o ? ~ref_q : ref_q;
      OC_LOW:    ref_nxt = 1'b0;
      OC_HIGH:   ref_nxt = 1'b1;
      OC_PWM_A:  ref_nxt = pwm_lvl;
      OC_PWM_B:  ref_nxt = ~pwm_lvl;
      default:   ref_nxt = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_nxt;
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/oc_pin_drive.sv
module oc_pin_drive #(
  parameter bit REF_INV = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  input  logic en_i,
  input  logic pol_i,
  input  logic idle_i,
  output logic pin_o
);
  logic pin_q;
  logic lvl;

  assign lvl = ref_i ^ REF_INV ^ pol_i;

  always_ff @(posedge clk) begin
    if (rst)       pin_q <= 1'b0;
    else if (en_i) pin_q <= lvl;
    else           pin_q <= idle_i;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/oc_chan.sv
module oc_chan
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             count_down_i,
  input  logic             update_i,
  input  logic [2:0]       mode_i,
  input  logic             preload_en_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             flag_clr_i,
  input  logic             main_en_i,
  input  logic             main_pol_i,
  input  logic             main_idle_i,
  input  logic             comp_en_i,
  input  logic             comp_pol_i,
  input  logic             comp_idle_i,
  output logic             ref_o,
  output logic             out_main_o,
  output logic             out_comp_o,
  output logic             match_flag_o
);
  logic [CNT_W-1:0]   cmp_act;
  logic               hit;
  logic               ref_lvl;
  logic               flag_q;
  logic [OC_PINS-1:0] pin_en, pin_pol, pin_idle, pin_out;

  oc_cmp_hold #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .wr_i(cmp_wr_i), .wdata_i(cmp_wdata_i),
    .pre_en_i(preload_en_i), .update_i(update_i), .act_o(cmp_act)
  );

  oc_ref_gen #(.W(CNT_W)) u_ref (
    .clk(clk), .rst(rst), .mode_i(oc_mode_e'(mode_i)), .count_i(count_i),
    .down_i(count_down_i), .cmp_i(cmp_act), .hit_o(hit), .ref_o(ref_lvl)
  );

  // sticky flag: a match in the same cycle wins over a clear
  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b0;
    else if (hit)        flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign pin_en   = {comp_en_i,   main_en_i};
  assign pin_pol  = {comp_pol_i,  main_pol_i};
  assign pin_idle = {comp_idle_i, main_idle_i};

  for (genvar g = 0; g < OC_PINS; g++) begin : g_pin
    oc_pin_drive #(.REF_INV(g == 1)) u_pin (
      .clk(clk), .rst(rst), .ref_i(ref_lvl), .en_i(pin_en[g]),
      .pol_i(pin_pol[g]), .idle_i(pin_idle[g]), .pin_o(pin_out[g])
    );
  end

  assign ref_o        = ref_lvl;
  assign out_main_o   = pin_out[0];
  assign out_comp_o   = pin_out[1];
  assign match_flag_o = flag_q;
endmodule

// File: rtl/oc_chan_chk.sv
module oc_chan_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_i,
  input logic       flag_clr_i,
  input logic       main_en_i,
  input logic       main_pol_i,
  input logic       main_idle_i,
  input logic       comp_en_i,
  input logic       comp_pol_i,
  input logic       comp_idle_i,
  input logic       ref_o,
  input logic       out_main_o,
  input logic       out_comp_o,
  input logic       match_flag_o
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    mode_i == 3'b000 |=> $stable(ref_o)); // R2
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    mode_i == 3'b100 |=> !ref_o); // R5
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    mode_i == 3'b101 |=> ref_o); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    match_flag_o && !flag_clr_i |=> match_flag_o); // R9
  AST_MAIN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    main_en_i |=> out_main_o == ($past(ref_o) ^ $past(main_pol_i))); // R10
  AST_MAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !main_en_i |=> out_main_o == $past(main_idle_i)); // R10
  AST_COMP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    comp_en_i |=> out_comp_o == (!$past(ref_o) ^ $past(comp_pol_i))); // R11
  AST_COMP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !comp_en_i |=> out_comp_o == $past(comp_idle_i)); // R11
endmodule

bind oc_chan oc_chan_chk u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .flag_clr_i(flag_clr_i),
  .main_en_i(main_en_i), .main_pol_i(main_pol_i), .main_idle_i(main_idle_i),
  .comp_en_i(comp_en_i), .comp_pol_i(comp_pol_i), .comp_idle_i(comp_idle_i),
  .ref_o(ref_o), .out_main_o(out_main_o), .out_comp_o(out_comp_o),
  .match_flag_o(match_flag_o)
);

// File: tb/oc_chan_tb_top.sv
`timescale 1ns/1ps
module oc_chan_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] count_i = '0;
  logic count_down_i = 1'b0, update_i = 1'b0, preload_en_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic cmp_wr_i = 1'b0;
  logic [CNT_W-1:0] cmp_wdata_i = '0;
  logic flag_clr_i = 1'b0;
  logic main_en_i = 1'b0, main_pol_i = 1'b0, main_idle_i = 1'b0;
  logic comp_en_i = 1'b0, comp_pol_i = 1'b0, comp_idle_i = 1'b0;
  logic ref_o, out_main_o, out_comp_o, match_flag_o;

  always #5 clk = ~clk;

  oc_chan #(.CNT_W(CNT_W)) dut_i (.*);

  // expected state, built from the requirements
  logic [CNT_W-1:0] e_act, e_shadow;
  logic e_ref, e_flag, e_main, e_comp;
  int n_chk = 0, n_err = 0, wd = 0;
  string ref_tag = "R1";

  function automatic logic exp_ref(logic [2:0] m, logic [CNT_W-1:0] c, logic dn,
                                   logic [CNT_W-1:0] cv, logic cur);
    logic hit = (c == cv);
    logic pwm = dn ? (c <= cv) : (c < cv);
    case (m)
      3'b001: return hit ? 1'b1 : cur;
      3'b010: return hit ? 1'b0 : cur;
      3'b011: return hit ? ~cur : cur;
      3'b100: return 1'b0;
      3'b101: return 1'b1;
      3'b110: return pwm;
      3'b111: return ~pwm;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_act <= '0; e_shadow <= '0; e_ref <= 0; e_flag <= 0; e_main <= 0; e_comp <= 0;
    end else begin
      logic [CNT_W-1:0] sh_n;
      sh_n = cmp_wr_i ? cmp_wdata_i : e_shadow;
      e_shadow <= sh_n;
      if (!preload_en_i && cmp_wr_i) e_act <= cmp_wdata_i;
      else if (preload_en_i && update_i) e_act <= sh_n;
      e_ref  <= exp_ref(mode_i, count_i, count_down_i, e_act, e_ref);
      e_flag <= (count_i == e_act) ? 1'b1 : (flag_clr_i ? 1'b0 : e_flag);
      e_main <= main_en_i ? (e_ref ^ main_pol_i) : main_idle_i;
      e_comp <= comp_en_i ? (~e_ref ^ comp_pol_i) : comp_idle_i;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(ref_tag, "ref_o", ref_o, e_ref);
    chk("R9", "match_flag_o", match_flag_o, e_flag);
    chk("R10", "out_main_o", out_main_o, e_main);
    chk("R11", "out_comp_o", out_comp_o, e_comp);
  endtask

  // timebase emulation state
  int per = 20;
  logic [CNT_W-1:0] tb_cnt = '0;

  task automatic tick_timebase(bit center);
    update_i = 1'b0;
    if (!count_down_i) begin
      if (tb_cnt >= CNT_W'(per)) begin
        update_i = 1'b1;
        if (center) begin count_down_i = 1'b1; tb_cnt = tb_cnt - 1; end
        else tb_cnt = '0;
      end else tb_cnt = tb_cnt + 1;
    end else begin
      if (tb_cnt == '0) begin
        update_i = 1'b1;
        if (center) begin count_down_i = 1'b0; tb_cnt = tb_cnt + 1; end
        else tb_cnt = CNT_W'(per);
      end else tb_cnt = tb_cnt - 1;
    end
    count_i = tb_cnt;
  endtask

  task automatic run_phase(logic [2:0] m, string tag, int cycles, bit rnd_cfg);
    bit center;
    center = $urandom_range(0, 1);
    mode_i = m;
    ref_tag = tag;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_all();
      tick_timebase(center);
      cmp_wr_i = ($urandom_range(0, 9) == 0);
      cmp_wdata_i = CNT_W'($urandom_range(0, per + 2));
      flag_clr_i = ($urandom_range(0, 3) == 0);
      if (rnd_cfg && $urandom_range(0, 15) == 0) begin
        {main_en_i, main_pol_i, main_idle_i} = 3'($urandom);
        {comp_en_i, comp_pol_i, comp_idle_i} = 3'($urandom);
        preload_en_i = $urandom_range(0, 1);
      end
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c01));
    // R1: reset state, during reset and just after release
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ref_o in reset", ref_o, 1'b0);
    chk("R1", "out_main_o in reset", out_main_o, 1'b0);
    chk("R1", "out_comp_o in reset", out_comp_o, 1'b0);
    chk("R1", "match_flag_o in reset", match_flag_o, 1'b0);
    count_i = 16'd7;
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ref_o after reset", ref_o, 1'b0);
    chk("R1", "out_main_o after reset", out_main_o, 1'b0);
    chk("R1", "match_flag_o after reset (count 7, cmp 0)", match_flag_o, 1'b0);
    // R8 directed: active compare starts at 0, so count 0 sets the flag
    count_i = '0; tb_cnt = '0;
    @(negedge clk);
    chk("R8", "flag after count equals reset compare 0", match_flag_o, 1'b1);

    // directed R8: buffered vs immediate compare with PWM
    main_en_i = 1'b1; comp_en_i = 1'b1;
    preload_en_i = 1'b1; mode_i = 3'b110; ref_tag = "R8";
    count_down_i = 1'b0; count_i = 16'd5;
    cmp_wr_i = 1'b1; cmp_wdata_i = 16'd10;
    @(negedge clk); check_all();
    cmp_wr_i = 1'b0;
    @(negedge clk); check_all();
    chk("R8", "buffered value not active before update", ref_o, 1'b0);
    update_i = 1'b1;
    @(negedge clk); check_all();
    update_i = 1'b0;
    @(negedge clk); check_all();
    chk("R8", "buffered value active after update", ref_o, 1'b1);
    preload_en_i = 1'b0; cmp_wr_i = 1'b1; cmp_wdata_i = 16'd3;
    @(negedge clk); check_all();
    cmp_wr_i = 1'b0;
    @(negedge clk); check_all();
    chk("R8", "immediate value active next cycle", ref_o, 1'b0);

    // random phases per mode
    run_phase(3'b000, "R2", 300, 1'b1);
    run_phase(3'b101, "R5", 60, 1'b1);
    run_phase(3'b000, "R2", 200, 1'b1);
    run_phase(3'b001, "R3", 300, 1'b1);
    run_phase(3'b010, "R3", 300, 1'b1);
    run_phase(3'b011, "R4", 400, 1'b1);
    run_phase(3'b100, "R5", 150, 1'b1);
    run_phase(3'b101, "R5", 150, 1'b1);
    run_phase(3'b110, "R6", 500, 1'b1);
    run_phase(3'b111, "R7", 500, 1'b1);
    preload_en_i = 1'b1;
    run_phase(3'b110, "R8", 400, 1'b0);
    preload_en_i = 1'b0;
    run_phase(3'b111, "R8", 300, 1'b0);

    @(negedge clk);
    check_all();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule